// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter built from identical narrow stages. Each stage has a parallel preset, two count-enable inputs and a combinational carry. The default configuration chains two 4-bit stages into an 8-bit counter. All stages share the clock, the preset strobe and the enable P input. The enable T input of each stage above the first is driven by the carry of the stage below it. The chained counter therefore advances as a single synchronous counter, with no ripple delay between edges.

An active-low clear zeroes the count at once, without waiting for a clock edge. Its release is re-timed to the clock through a short synchroniser, so the first preset or count after a clear always happens on a clean edge. Preset has priority over counting. Only enable T takes part in the carry, so enable P can pause the whole chain without disturbing the carry path.

Top module: `cnt_chain`

## Requirements
- R1: While clear_n is low, count is 0 and carry_out is 0 immediately, whatever the clock, load_n, enables or data are doing.
- R2: With the clear released and load_n low, a rising clock edge copies data_in to count; en_p and en_t have no effect on that edge.
- R3: With load_n high, count increases by one on a rising edge when en_p and en_t are both high.
- R4: With load_n high, count holds if en_p is low or en_t is low.
- R5: Between rising edges, count does not change when load_n, the enables or data_in change; only clear_n acts without an edge.
- R6: carry_out is high exactly when en_t is high and every bit of count is 1, in the same cycle, with no register in the path.
- R7: Counting from the all-ones value wraps count to 0 on the next enabled edge.
- R8: Stage k+1 is enabled by the carry of stage k, so a lower stage at its maximum carries into the next stage on a counting edge; with en_t low, no stage advances.
- R9: After clear_n rises, the first RST_SYNC_STAGES rising edges (default 2) leave count at 0 even if load_n is low; the edge after them acts normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clear_n | input | 1 | Active-low asynchronous clear, with synchronised release |
| load_n | input | 1 | Active-low synchronous preset strobe |
| en_p | input | 1 | Count enable shared by all stages, not part of the carry |
| en_t | input | 1 | Count enable of the lowest stage, part of the carry |
| data_in | input | STAGES*STAGE_W | Preset value |
| count | output | STAGES*STAGE_W | Counter value |
| carry_out | output | 1 | Carry from the top stage |

## Verification
Preset, count and hold results appear at count one rising edge after the controls are set up. The bench drives at the falling edge, queues the expected value for the next edge, and a monitor compares a quarter period after that rising edge. carry_out depends on the count and the current en_t without a register, so it is compared in the same sample. The effect of clear is checked one time step after clear_n falls. Its release is checked edge by edge, with the first two edges expected to leave count at 0. Robustness to input changes without an edge is checked a few time steps after the inputs move in mid-cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
   localparam int unsigned DEF_STAGE_W = 4;
   localparam int unsigned DEF_STAGES  = 2;
   localparam int unsigned DEF_SYNC    = 2;

   // Next-state control for one stage, in priority order.
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_COUNT = 2'd1,
      OP_PRESET = 2'd2
   } stage_op_e;

   function automatic stage_op_e pick_op(input logic load_n, input logic ep, input logic et);
      if (!load_n)        return OP_PRESET;
      else if (ep && et)  return OP_COUNT;
      else                return OP_HOLD;
   endfunction
endpackage

// File: rtl/cnt_clr_sync.sv
module cnt_clr_sync #(
   parameter int unsigned SYNC_STAGES = cnt_pkg::DEF_SYNC
) (
   input  logic clk,
   input  logic clear_n,
   output logic rst_n
);
   generate
      if (SYNC_STAGES == 0) begin : g_bypass
         assign rst_n = clear_n;
      end else begin : g_sync
         localparam logic [SYNC_STAGES-1:0] ONE = SYNC_STAGES'(1);
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge clear_n) begin
            if (!clear_n) sh <= '0;
            else          sh <= (sh << 1) | ONE;
         end
         assign rst_n = sh[SYNC_STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage #(
   parameter int unsigned STAGE_W = cnt_pkg::DEF_STAGE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_n,
   input  logic               en_p,
   input  logic               en_t,
   input  logic [STAGE_W-1:0] din,
   output logic [STAGE_W-1:0] q,
   output logic               rco
);
   import cnt_pkg::*;

   stage_op_e op;
   assign op = pick_op(load_n, en_p, en_t);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else begin
         case (op)
            OP_PRESET: q <= din;
            OP_COUNT:  q <= q + 1'b1;
            default:   q <= q;
         endcase
      end
   end

   assign rco = en_t & (&q);

   // R9: first sampled edge after release still shows the cleared value
   p_release_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (q == '0));
   // R2: preset copies data regardless of enables
   p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> (q == $past(din)));
   // R3: counting step
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && en_p && en_t) |=> (q == STAGE_W'($past(q) + 1'b1)));
   // R4: hold when either enable is low
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !(en_p && en_t)) |=> $stable(q));
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
   parameter int unsigned STAGE_W         = cnt_pkg::DEF_STAGE_W,
   parameter int unsigned STAGES          = cnt_pkg::DEF_STAGES,
   parameter int unsigned RST_SYNC_STAGES = cnt_pkg::DEF_SYNC
) (
   input  logic                        clk,
   input  logic                        clear_n,
   input  logic                        load_n,
   input  logic                        en_p,
   input  logic                        en_t,
   input  logic [STAGES*STAGE_W-1:0]   data_in,
   output logic [STAGES*STAGE_W-1:0]   count,
   output logic                        carry_out
);
   localparam int unsigned TOT_W = STAGES * STAGE_W;

   generate
      if (STAGE_W < 1) begin : g_bad_width
         $error("cnt_chain: STAGE_W must be at least 1");
      end
      if (STAGES < 1) begin : g_bad_stages
         $error("cnt_chain: STAGES must be at least 1");
      end
      if (RST_SYNC_STAGES > 8) begin : g_bad_sync
         $error("cnt_chain: RST_SYNC_STAGES must not exceed 8");
      end
   endgenerate

   logic              rst_int_n;
   logic [STAGES:0]   t_chain;

   cnt_clr_sync #(.SYNC_STAGES(RST_SYNC_STAGES)) u_sync (
      .clk    (clk),
      .clear_n(clear_n),
      .rst_n  (rst_int_n)
   );

   assign t_chain[0] = en_t;

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         cnt_stage #(.STAGE_W(STAGE_W)) u_stage (
            .clk   (clk),
            .rst_n (rst_int_n),
            .load_n(load_n),
            .en_p  (en_p),
            .en_t  (t_chain[k]),
            .din   (data_in[k*STAGE_W +: STAGE_W]),
            .q     (count[k*STAGE_W +: STAGE_W]),
            .rco   (t_chain[k+1])
         );
      end
   endgenerate

   assign carry_out = t_chain[STAGES];

   // R6: carry agrees with the full count and en_t
   p_carry_r6: assert property (@(posedge clk) disable iff (!clear_n)
      carry_out == (en_t && (count == {TOT_W{1'b1}})));
   // R1: clear forces zero output
   p_clear_zero_r1: assert property (@(posedge clk) disable iff (clear_n)
      (count == '0) && !carry_out);
   // R8: chained stages step as one wide counter
   p_cascade_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
      (load_n && en_p && en_t) |=> (count == TOT_W'($past(count) + 1'b1)));
   // R7: wrap from all ones to zero
   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
      (load_n && en_p && en_t && (count == {TOT_W{1'b1}})) |=> (count == '0));
endmodule

// File: tb/cnt_chain_tb.sv
module cnt_chain_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W    = 8;
   localparam int SYNC = 2;

   typedef struct {
      logic [W-1:0] cnt;
      logic         cy;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         clear_n = 1'b0;
   logic         load_n = 1'b1;
   logic         en_p = 1'b0;
   logic         en_t = 1'b0;
   logic [W-1:0] data_in = '0;
   logic [W-1:0] count;
   logic         carry_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   exp_t          sb[$];
   logic [W-1:0]  model = '0;
   int            rel = 0;
   bit            release_pending = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cnt_chain #(.STAGE_W(4), .STAGES(2), .RST_SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
      .data_in(data_in), .count(count), .carry_out(carry_out)
   );

   task automatic check(input string tag, input logic [W-1:0] ec, input logic ey);
      checks++;
      if (count !== ec || carry_out !== ey) begin
         errors++;
         $display("FAIL %s: count=%h carry=%b expected count=%h carry=%b", tag, count, carry_out, ec, ey);
      end
   endtask

   // Driver: set inputs at the falling edge, queue the result due after the next rising edge.
   task automatic cycle(input logic ld, input logic p, input logic t, input logic [W-1:0] d, input string tag);
      exp_t e;
      @(negedge clk);
      if (release_pending) begin
         clear_n = 1'b1;
         rel = SYNC;
         release_pending = 1'b0;
      end
      load_n = ld; en_p = p; en_t = t; data_in = d;
      if (rel > 0) begin
         model = '0;
         rel--;
      end else if (!ld) model = d;
      else if (p && t)  model = model + 1'b1;
      e.cnt = model;
      e.cy  = t && (model == {W{1'b1}});
      e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: compare a quarter period after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, e.cnt, e.cy);
         end
      end
   end

   task automatic apply_clear();
      @(posedge clk);
      #(CLK_PERIOD/4 + 1);
      clear_n = 1'b0;
      #1;
      check("R1 immediate clear", '0, 1'b0);
      model = '0;
      @(negedge clk);
      load_n = 1'b0; en_p = 1'b1; en_t = 1'b1; data_in = 8'hC3;
      @(posedge clk);
      #1;
      check("R1 clear holds over edge", '0, 1'b0);
      release_pending = 1'b1;
   endtask

   task automatic no_edge_change();
      @(posedge clk);
      #(CLK_PERIOD/4 + 1);
      load_n = 1'b0; data_in = 8'hAA; en_p = 1'b1; en_t = 1'b0;
      #2;
      check("R5 no edge no change", model, 1'b0);
      load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
      #1;
      check("R5 no edge after enables", model, model == {W{1'b1}});
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (2) @(posedge clk);
      #1;
      check("R1 reset state", '0, 1'b0);
      release_pending = 1'b1;
      // R9: synchronised release, preset requested from the first edge
      cycle(1'b0, 1'b0, 1'b0, 8'h5A, "R9 edge 1 after release");
      cycle(1'b0, 1'b0, 1'b0, 8'h5A, "R9 edge 2 after release");
      cycle(1'b0, 1'b0, 1'b0, 8'h5A, "R9 first active edge");
      // R2: preset wins over enables
      cycle(1'b0, 1'b1, 1'b1, 8'h33, "R2 preset with enables high");
      // R3: counting
      cycle(1'b1, 1'b1, 1'b1, 8'h00, "R3 count");
      cycle(1'b1, 1'b1, 1'b1, 8'h00, "R3 count");
      // R4: hold
      cycle(1'b1, 1'b0, 1'b1, 8'hFF, "R4 hold en_p low");
      cycle(1'b1, 1'b1, 1'b0, 8'hFF, "R4 hold en_t low");
      cycle(1'b1, 1'b0, 1'b0, 8'hFF, "R4 hold both low");
      // R5: inputs move without an edge
      no_edge_change();
      // R8: carry between stages
      cycle(1'b0, 1'b0, 1'b0, 8'h0E, "R2 preset 0E");
      cycle(1'b1, 1'b1, 1'b1, 8'h00, "R6 low stage full, no top carry");
      cycle(1'b1, 1'b1, 1'b0, 8'h00, "R8 en_t low blocks chain");
      cycle(1'b1, 1'b1, 1'b1, 8'h00, "R8 low stage carries into upper");
      cycle(1'b1, 1'b1, 1'b1, 8'h00, "R8 continue");
      // R6/R7: top carry and wrap
      cycle(1'b0, 1'b1, 1'b0, 8'hFD, "R2 preset FD en_t low");
      cycle(1'b1, 1'b1, 1'b1, 8'h00, "R3 count to FE");
      cycle(1'b1, 1'b1, 1'b1, 8'h00, "R6 carry at all ones");
      cycle(1'b1, 1'b1, 1'b0, 8'h00, "R6 carry gated by en_t");
      cycle(1'b1, 1'b0, 1'b1, 8'h00, "R6 carry with en_p low");
      cycle(1'b1, 1'b1, 1'b1, 8'h00, "R7 wrap to zero");
      cycle(1'b1, 1'b1, 1'b1, 8'h00, "R7 count after wrap");
      // R1 mid-run clear, then R9 again
      cycle(1'b0, 1'b0, 1'b0, 8'h77, "R2 preset 77");
      apply_clear();
      cycle(1'b1, 1'b1, 1'b1, 8'h00, "R9 no count edge 1");
      cycle(1'b1, 1'b1, 1'b1, 8'h00, "R9 no count edge 2");
      cycle(1'b1, 1'b1, 1'b1, 8'h00, "R9 counts after sync");
      cycle(1'b0, 1'b0, 1'b1, 8'h9C, "R2 preset 9C");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule